// File: doc/BRIEF.md
# H-Bridge Control and Protection Sequencer

This block is the digital core of one full H-bridge. Each of the two direction inputs sets the level of one totem-pole leg. The block drives four gate enables, a high side and a low side for each leg. When the load current trips the current comparator, it turns the high sides off for a fixed number of cycles and then turns them back on, so the current is chopped at a constant off-time. A blanking counter restarts on every change of the output drive: when the bridge comes on, when a leg switches, and when the high sides return after a chop. When that counter runs out, the short-circuit comparator is checked. If it is still active, the block treats the condition as a short rather than an ordinary overcurrent.

A short, or a hot junction, forces all switches off and keeps them off. The fault output is active low. The latch stays set until the bridge is disabled or put to sleep. A separate warm flag makes the block ask the external comparator for a reduced current limit. Every input passes through a two-stage synchronizer. Each leg waits a fixed dead time whenever it changes from one side to the other.

Top module: `hbridge_ctrl`

## Requirements
- R1: After reset, all four gate enables are 0, `fault_n_o` is 1 and `ilim_low_o` is 0.
- R2: While the bridge runs, a leg whose input is 1 has its high side on and its low side off. A leg whose input is 0 has its low side on and its high side off. Each leg follows only its own input.
- R3: While `dis1_i` is 1 or `en_i` is 0, all four gate enables are 0.
- R4: `sleep_o` is 1 exactly when `en_i` is 0. `dis1_i` high leaves `sleep_o` at 0.
- R5: When a running leg changes level, both of its switches are off for exactly DEAD_CYC cycles. The high side and the low side of a leg are never on together.
- R6: A one-cycle `ilim_i` pulse turns both high sides off for exactly TOFF_CYC cycles. The low sides are not affected.
- R7: A short indication that ends before the blanking counter expires has no effect. The fault stays clear and the bridge keeps driving.
- R8: If `short_i` is still active when the blanking counter expires (BLANK_CYC cycles after a drive change), the block latches a fault. While latched, `fault_n_o` is 0 and all gates are off.
- R9: `hot_i` high while enabled latches a fault, with all gates off and `fault_n_o` at 0.
- R10: A latched fault persists after its cause goes away. A `dis1_i` pulse clears it, and so does `en_i` going low.
- R11: `ilim_low_o` follows the synchronized `warm_i` (1 selects the reduced current limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in1_i | input | 1 | Level command for leg 1 |
| in2_i | input | 1 | Level command for leg 2 |
| dis1_i | input | 1 | Disable, active high; outputs float |
| en_i | input | 1 | Enable, active low disable plus sleep |
| ilim_i | input | 1 | Current-limit comparator flag |
| short_i | input | 1 | Short-circuit comparator flag |
| warm_i | input | 1 | Warm-temperature flag |
| hot_i | input | 1 | Overtemperature flag |
| hs1_o | output | 1 | Leg 1 high-side gate enable |
| ls1_o | output | 1 | Leg 1 low-side gate enable |
| hs2_o | output | 1 | Leg 2 high-side gate enable |
| ls2_o | output | 1 | Leg 2 low-side gate enable |
| fault_n_o | output | 1 | Latched fault, active low |
| ilim_low_o | output | 1 | Selects the reduced current threshold |
| sleep_o | output | 1 | Sleep state indicator |

## Verification
The bench counts the cycles in which both switches of a leg are off around a level change. A design that skips the dead time, or that overlaps the two switches, fails that count. It also counts the high-side off cycles after a single current-limit pulse, which catches an off-time that is one cycle short or long. A short indication that clears inside the blanking window must leave the bridge running, which catches a design that trips on the raw comparator. A held short must trip it, and the trip must survive the removal of its cause until a disable is cycled, which catches a latch that clears by itself.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int DEAD_CYC  = 3,
  parameter int TOFF_CYC  = 20,
  parameter int BLANK_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in1_i,
  input  logic in2_i,
  input  logic dis1_i,
  input  logic en_i,
  input  logic ilim_i,
  input  logic short_i,
  input  logic warm_i,
  input  logic hot_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o,
  output logic fault_n_o,
  output logic ilim_low_o,
  output logic sleep_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int TW = $clog2(TOFF_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [7:0] raw, s1, s2;
  assign raw = {hot_i, warm_i, short_i, ilim_i, en_i, dis1_i, in2_i, in1_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic [1:0] in_s;
  logic dis_s, en_s, ilim_s, short_s, warm_s, hot_s;
  assign in_s    = s2[1:0];
  assign dis_s   = s2[2];
  assign en_s    = s2[3];
  assign ilim_s  = s2[4];
  assign short_s = s2[5];
  assign warm_s  = s2[6];
  assign hot_s   = s2[7];

  logic fault_q, run_d, clr, run;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [1:0] cur, chg, hs, ls;
  logic [DW-1:0] dcnt [2];

  assign clr = dis_s | ~en_s;
  assign run = ~clr & ~fault_q;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    assign chg[g] = run && dcnt[g] == '0 && in_s[g] != cur[g];
    assign hs[g]  = run && cur[g] && dcnt[g] == '0 && tcnt == '0;
    assign ls[g]  = run && !cur[g] && dcnt[g] == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cur[g]  <= 1'b0;
        dcnt[g] <= '0;
      end else if (!run) begin
        cur[g]  <= in_s[g];
        dcnt[g] <= '0;
      end else if (chg[g]) begin
        cur[g]  <= in_s[g];
        dcnt[g] <= DW'(DEAD_CYC);
      end else if (dcnt[g] != '0) begin
        dcnt[g] <= dcnt[g] - 1'b1;
      end
  end

  logic chop_start, chop_end, restart, short_trip;
  assign chop_start = run && ilim_s && tcnt == '0 && hs != 2'b00;
  assign chop_end   = run && tcnt == TW'(1);
  assign restart    = (run && !run_d) || chg != 2'b00 || chop_end;
  assign short_trip = run && bcnt == BW'(1) && short_s && !restart;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else if (!run) tcnt <= '0;
    else if (chop_start) tcnt <= TW'(TOFF_CYC);
    else if (tcnt != '0) tcnt <= tcnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (!run) bcnt <= '0;
    else if (restart) bcnt <= BW'(BLANK_CYC);
    else if (bcnt != '0) bcnt <= bcnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fault_q <= 1'b0;
      run_d   <= 1'b0;
    end else begin
      run_d <= run;
      if (clr) fault_q <= 1'b0;
      else if (hot_s || short_trip) fault_q <= 1'b1;
    end

  assign hs1_o      = hs[0];
  assign ls1_o      = ls[0];
  assign hs2_o      = hs[1];
  assign ls2_o      = ls[1];
  assign fault_n_o  = ~fault_q;
  assign ilim_low_o = warm_s;
  assign sleep_o    = ~en_s;

  AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1_o && ls1_o) && !(hs2_o && ls2_o)); // R5
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ls1_o) && run) |=> !hs1_o); // R5
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !(hs1_o || ls1_o || hs2_o || ls2_o)); // R3
  AST_CHOP_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt != '0) |-> !(hs1_o || hs2_o)); // R6
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> !(hs1_o || ls1_o || hs2_o || ls2_o)); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q); // R10
  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> ($past(hot_s) || $past(bcnt == BW'(1) && short_s))); // R7
endmodule

// File: tb/hbridge_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_ctrl_tb;
  localparam int DEAD = 3, TOFF = 20, BLANK = 12;
  logic clk = 0, rst_n = 0;
  logic in1 = 0, in2 = 0, dis1 = 0, en = 0, ilim = 0, shrt = 0, warm = 0, hot = 0;
  logic hs1, ls1, hs2, ls2, fault_n, ilim_low, sleep;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hbridge_ctrl #(.DEAD_CYC(DEAD), .TOFF_CYC(TOFF), .BLANK_CYC(BLANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .in1_i(in1), .in2_i(in2), .dis1_i(dis1), .en_i(en),
    .ilim_i(ilim), .short_i(shrt), .warm_i(warm), .hot_i(hot),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2),
    .fault_n_o(fault_n), .ilim_low_o(ilim_low), .sleep_o(sleep));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gates();
    return {hs1, ls1, hs2, ls2};
  endfunction

  task automatic t_reset();
    check("R1 gates", gates(), 0);
    check("R1 fault_n", fault_n, 1);
    check("R1 ilim_low", ilim_low, 0);
  endtask

  task automatic t_sleep_disable();
    check("R4 sleep when en low", sleep, 1);
    check("R3 off in sleep", gates(), 0);
    en = 1; dis1 = 1; cyc(5);
    check("R4 dis1 not sleep", sleep, 0);
    check("R3 off with dis1", gates(), 0);
    dis1 = 0; cyc(5);
  endtask

  task automatic t_levels();
    in1 = 1; in2 = 0; cyc(10);
    check("R2 in1=1 in2=0", gates(), 4'b1001);
    in1 = 0; in2 = 1; cyc(10);
    check("R2 in1=0 in2=1", gates(), 4'b0110);
    in1 = 1; in2 = 1; cyc(10);
    check("R2 both high", gates(), 4'b1010);
    in1 = 1; in2 = 0; cyc(30);
    check("R2 back", gates(), 4'b1001);
  endtask

  task automatic t_dead();
    int off = 0, both = 0;
    in1 = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!hs1 && !ls1) off++;
      if (hs1 && ls1) both++;
    end
    check("R5 dead cycles 1->0", off, DEAD);
    check("R5 no overlap", both, 0);
    check("R5 settled low", gates(), 4'b0101);
    off = 0;
    in1 = 1;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!hs1 && !ls1) off++;
    end
    check("R5 dead cycles 0->1", off, DEAD);
    cyc(20);
  endtask

  task automatic t_chop();
    int off = 0, lsoff = 0;
    ilim = 1; cyc(1); ilim = 0;
    for (int i = 0; i < 50; i++) begin
      cyc(1);
      if (!hs1) off++;
      if (!ls2) lsoff++;
    end
    check("R6 off-time", off, TOFF);
    check("R6 low side kept", lsoff, 0);
    cyc(20);
  endtask

  task automatic t_short_blank();
    in2 = 1; shrt = 1; cyc(4); shrt = 0;
    cyc(40);
    check("R7 fault_n", fault_n, 1);
    check("R7 driving", gates(), 4'b1010);
  endtask

  task automatic t_short_latch();
    shrt = 1; in2 = 0; cyc(30);
    check("R8 fault_n", fault_n, 0);
    check("R8 gates off", gates(), 0);
    shrt = 0; cyc(20);
    check("R10 hold", fault_n, 0);
    dis1 = 1; cyc(2); dis1 = 0; cyc(6);
    check("R10 cleared by dis1", fault_n, 1);
    check("R10 driving again", gates(), 4'b1001);
  endtask

  task automatic t_hot();
    hot = 1; cyc(5);
    check("R9 fault_n", fault_n, 0);
    check("R9 gates off", gates(), 0);
    hot = 0; cyc(10);
    check("R10 hold after hot", fault_n, 0);
    en = 0; cyc(2); en = 1; cyc(6);
    check("R10 cleared by en", fault_n, 1);
    check("R10 driving after en", gates(), 4'b1001);
  endtask

  task automatic t_warm();
    warm = 1; cyc(4);
    check("R11 warm", ilim_low, 1);
    warm = 0; cyc(4);
    check("R11 nominal", ilim_low, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(5);
    t_sleep_disable();
    t_levels();
    t_dead();
    t_chop();
    t_short_blank();
    t_short_latch();
    t_hot();
    t_warm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule